// File: doc/BRIEF.md
# Timer0 Counter with Shared Prescaler

This block is an 8-bit up-counter for a small microcontroller core. The counter advances either on the core's instruction-cycle strobe or on a chosen edge of an asynchronous input pin. Before it reaches the counter, the pin passes through a two-flop synchronizer and an edge detector. One 8-bit divider sits in the path. A single assign bit in the option register gives that divider either to the counter or to the watchdog's tick stream, so only one of the two is ever divided.

When the divider serves the counter, it divides the count source by 2^(rate+1). When it serves the watchdog, it divides the watchdog tick by 2^rate, and the counter then sees every source event. Firmware loads the counter through a write port. A load clears the divider when the divider belongs to the counter, and it suppresses counting for the next two instruction cycles. When the counter rolls over from its top value to zero, the block emits a one-cycle overflow pulse for the interrupt logic. The watchdog oscillator and the interrupt flag register sit outside this block.

Top module: `t0_timer`

## Requirements
- R1: After synchronous reset the option register reads 8'hFF, the counter reads 0, and the overflow and watchdog-tick outputs are 0.
- R2: With option bit 5 = 0 (internal source) and bit 3 = 1 (divider on watchdog), the counter advances by one for every clock in which `cyc_en` is high.
- R3: With bit 5 = 1 and bit 4 = 0, a low-to-high change of `ext_clk_in` advances the counter, visible on `cnt_q` after the third rising `clk` edge that samples the new pin level. A high-to-low change has no effect.
- R4: With bit 5 = 1 and bit 4 = 1, only a high-to-low change of `ext_clk_in` advances the counter, with the same three-edge latency.
- R5: With bit 3 = 0, the counter advances once per 2^(rate+1) source events, where rate is option bits 2..0.
- R6: With bit 3 = 1, `wdt_tick_out` pulses once per 2^rate `wdt_tick_in` pulses. With bit 3 = 0, `wdt_tick_in` is ignored and `wdt_tick_out` stays 0.
- R7: When an increment takes the counter from 8'hFF to 0, `ovf_pulse` is high for exactly the one cycle in which `cnt_q` first reads 0. A load never raises it.
- R8: A counter write loads `cnt_wdata` on the next edge. It clears the divider when bit 3 = 0, and no increment takes effect until two further `cyc_en` strobes have passed.
- R9: An option write that changes bit 3 clears the divider, so the next divided tick needs the full ratio of source events.
- R10: An option write stores all eight bits, and `opt_q` returns them on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Instruction-cycle strobe, one clock wide |
| ext_clk_in | input | 1 | Asynchronous external count pin |
| wdt_tick_in | input | 1 | Undivided watchdog oscillator tick, one clock wide |
| opt_wr | input | 1 | Option register write strobe |
| opt_wdata | input | 8 | Option register write data |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W | Counter write data |
| opt_q | output | 8 | Option register contents |
| cnt_q | output | CNT_W | Counter value |
| ovf_pulse | output | 1 | One-cycle rollover pulse |
| wdt_tick_out | output | 1 | Divided tick toward the watchdog |

## Verification
A wrong divider count shows at the ports as an increment or a watchdog pulse one or more source events early or late, typically within one divide period after a clear. A divider that was not cleared is caught right after an assignment switch or a counter load, because the first tick comes too soon. A hold counter that is off by one shows as an increment one instruction cycle too early or too late after a load. An error in the synchronizer depth or the edge polarity shows within three clocks of a pin transition. A bench model that runs clock by clock compares every output on every cycle, so any of these errors is reported in the cycle where it first appears.

// File: rtl/t0_pkg.sv
`timescale 1ns/1ps
package t0_pkg;
  localparam int OPT_W = 8;
  localparam int RATE_W = 3;
  localparam logic [OPT_W-1:0] OPT_RESET = 8'hFF;

  // Option register layout, MSB first
  typedef struct packed {
    logic [1:0]        spare;     // stored only, used by neighbouring logic
    logic              src_ext;   // 1: external pin, 0: instruction cycle
    logic              edge_fall; // 1: falling pin edge counts
    logic              to_wdt;    // 1: divider serves the watchdog
    logic [RATE_W-1:0] rate;      // divider rate select
  } t0_opt_t;
endpackage

// File: rtl/t0_edge_sync.sv
`timescale 1ns/1ps
module t0_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], pin};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/t0_prescaler.sv
`timescale 1ns/1ps
module t0_prescaler #(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              clear,
  input  logic              to_wdt,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int SEL_W = RATE_W + 1;

  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] mask;
  logic [SEL_W-1:0] span;

  // number of low divider bits that must be all ones for a tick
  assign span = to_wdt ? {1'b0, rate} : ({1'b0, rate} + SEL_W'(1));

  genvar gi;
  generate
    for (gi = 0; gi < PRE_W; gi++) begin : g_mask
      assign mask[gi] = (gi < int'(span));
    end
  endgenerate

  assign tick = step & ((pcnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clear) pcnt <= '0;
    else if (step)    pcnt <= pcnt + PRE_W'(1);
  end
endmodule

// File: rtl/t0_counter.sv
`timescale 1ns/1ps
module t0_counter #(
  parameter int CNT_W    = 8,
  parameter int HOLD_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_en,
  input  logic             inc,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf,
  output logic             busy
);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  logic [HOLD_W-1:0] hold;

  assign busy = (hold != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      hold  <= '0;
      ovf   <= 1'b0;
    end else if (wr) begin
      cnt_q <= wdata;
      hold  <= HOLD_W'(HOLD_CYC);
      ovf   <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (cyc_en && busy) hold <= hold - HOLD_W'(1);
      if (inc && !busy) begin
        cnt_q <= cnt_q + CNT_W'(1);
        ovf   <= &cnt_q;
      end
    end
  end
endmodule

// File: rtl/t0_timer.sv
`timescale 1ns/1ps
module t0_timer
  import t0_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_en,
  input  logic             ext_clk_in,
  input  logic             wdt_tick_in,
  input  logic             opt_wr,
  input  logic [OPT_W-1:0] opt_wdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [OPT_W-1:0] opt_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_pulse,
  output logic             wdt_tick_out
);
  t0_opt_t opt;
  logic    pin_rise, pin_fall;
  logic    src_evt, pre_step, pre_clear, pre_tick, cnt_inc, hold_busy;
  t0_opt_t opt_new;

  assign opt_new = t0_opt_t'(opt_wdata);

  always_ff @(posedge clk) begin
    if (rst)         opt <= t0_opt_t'(OPT_RESET);
    else if (opt_wr) opt <= opt_new;
  end
  assign opt_q = opt;

  t0_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .pin  (ext_clk_in),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  assign src_evt   = opt.src_ext ? (opt.edge_fall ? pin_fall : pin_rise) : cyc_en;
  assign pre_step  = opt.to_wdt ? wdt_tick_in : (src_evt & ~hold_busy);
  assign pre_clear = (cnt_wr & ~opt.to_wdt) | (opt_wr & (opt_new.to_wdt != opt.to_wdt));
  assign cnt_inc   = opt.to_wdt ? src_evt : pre_tick;

  t0_prescaler #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .step   (pre_step),
    .clear  (pre_clear),
    .to_wdt (opt.to_wdt),
    .rate   (opt.rate),
    .tick   (pre_tick)
  );

  t0_counter #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .cyc_en (cyc_en),
    .inc    (cnt_inc),
    .wr     (cnt_wr),
    .wdata  (cnt_wdata),
    .cnt_q  (cnt_q),
    .ovf    (ovf_pulse),
    .busy   (hold_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) wdt_tick_out <= 1'b0;
    else     wdt_tick_out <= opt.to_wdt & pre_tick;
  end
endmodule

// File: rtl/t0_timer_chk.sv
`timescale 1ns/1ps
module t0_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             opt_wr,
  input logic [7:0]       opt_wdata,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [7:0]       opt_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ovf_pulse,
  input logic             wdt_tick_out
);
  p_ovf_zero_r7: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> (cnt_q == '0));

  p_ovf_from_top_r7: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> ($past(cnt_q) == {CNT_W{1'b1}}));

  p_wdt_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    wdt_tick_out |-> $past(opt_q[3]));

  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt_q == $past(cnt_wdata)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_wr ##1 !cnt_wr |=> $stable(cnt_q));

  p_opt_store_r10: assert property (@(posedge clk) disable iff (rst)
    opt_wr |=> (opt_q == $past(opt_wdata)));

  p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1))));
endmodule

bind t0_timer t0_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .opt_wr       (opt_wr),
  .opt_wdata    (opt_wdata),
  .cnt_wr       (cnt_wr),
  .cnt_wdata    (cnt_wdata),
  .opt_q        (opt_q),
  .cnt_q        (cnt_q),
  .ovf_pulse    (ovf_pulse),
  .wdt_tick_out (wdt_tick_out)
);

// File: tb/test_t0_timer.sv
`timescale 1ns/1ps
module test_t0_timer;
  localparam int CNT_W = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cyc_en = 1'b0, ext_clk_in = 1'b0, wdt_tick_in = 1'b0;
  logic opt_wr = 1'b0, cnt_wr = 1'b0;
  logic [7:0] opt_wdata = '0;
  logic [CNT_W-1:0] cnt_wdata = '0;
  logic [7:0] opt_q;
  logic [CNT_W-1:0] cnt_q;
  logic ovf_pulse, wdt_tick_out;

  t0_timer #(.CNT_W(CNT_W)) i_t0_timer (
    .clk(clk), .rst(rst), .cyc_en(cyc_en), .ext_clk_in(ext_clk_in),
    .wdt_tick_in(wdt_tick_in), .opt_wr(opt_wr), .opt_wdata(opt_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .opt_q(opt_q), .cnt_q(cnt_q),
    .ovf_pulse(ovf_pulse), .wdt_tick_out(wdt_tick_out)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  string phase = "R1";
  int cyc_div = 1, cyc_ph = 0;
  bit cyc_on = 1'b1, running = 1'b0, done = 1'b0;
  int wpulses = 0;

  // behavioural reference state
  int m_opt = 255, m_cnt = 0, m_pre = 0, m_hold = 0;
  bit m_ovf = 1'b0, m_wtk = 1'b0;
  bit hist[$] = '{1'b0, 1'b0, 1'b0};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin : ref_model
    int rate, dv;
    bit psa, srcx, efall, rise, fall, sev, pstep, tick, inc, ok;
    if (rst) begin
      m_opt = 255; m_cnt = 0; m_pre = 0; m_hold = 0;
      m_ovf = 1'b0; m_wtk = 1'b0;
      hist = '{1'b0, 1'b0, 1'b0};
    end else begin
      rate  = m_opt & 7;
      psa   = ((m_opt >> 3) & 1) != 0;
      efall = ((m_opt >> 4) & 1) != 0;
      srcx  = ((m_opt >> 5) & 1) != 0;
      rise  = hist[1] && !hist[2];
      fall  = !hist[1] && hist[2];
      sev   = srcx ? (efall ? fall : rise) : cyc_en;
      dv    = psa ? (1 << rate) : (1 << (rate + 1));
      ok    = (m_hold == 0);
      pstep = psa ? wdt_tick_in : (sev && ok);
      tick  = pstep && (((m_pre + 1) % dv) == 0);
      inc   = psa ? sev : tick;
      m_ovf = 1'b0;
      m_wtk = psa && tick;
      if (pstep) m_pre = (m_pre + 1) % 256;
      if (cnt_wr) begin
        m_cnt = int'(cnt_wdata); m_hold = 2;
        if (!psa) m_pre = 0;
      end else begin
        if (cyc_en && m_hold > 0) m_hold--;
        if (inc && ok) begin
          if (m_cnt == 255) m_ovf = 1'b1;
          m_cnt = (m_cnt + 1) % 256;
        end
      end
      if (opt_wr) begin
        if (((int'(opt_wdata) ^ m_opt) & 8) != 0) m_pre = 0;
        m_opt = int'(opt_wdata);
      end
      hist.push_front(ext_clk_in);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (running && !rst) begin
      check(int'(cnt_q) == m_cnt, {phase, " cnt_q"}, int'(cnt_q), m_cnt);
      check(int'(opt_q) == m_opt, {phase, " opt_q"}, int'(opt_q), m_opt);
      check(ovf_pulse == m_ovf, {phase, " ovf_pulse"}, int'(ovf_pulse), int'(m_ovf));
      check(wdt_tick_out == m_wtk, {phase, " wdt_tick_out"}, int'(wdt_tick_out), int'(m_wtk));
    end
    if (wdt_tick_out) wpulses++;
  end

  task automatic clk1();
    cyc_en = cyc_on && (cyc_ph == 0);
    cyc_ph = (cyc_ph + 1) % cyc_div;
    @(negedge clk);
  endtask

  task automatic clkn(input int n);
    for (int i = 0; i < n; i++) clk1();
  endtask

  task automatic wr_opt(input logic [7:0] v);
    opt_wr = 1'b1; opt_wdata = v; clk1(); opt_wr = 1'b0;
  endtask

  task automatic wr_cnt(input logic [CNT_W-1:0] v);
    cnt_wr = 1'b1; cnt_wdata = v; clk1(); cnt_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    running = 1'b1;
    // R1 reset state
    check(opt_q == 8'hFF, "R1 opt_q", int'(opt_q), 255);
    check(cnt_q == '0, "R1 cnt_q", int'(cnt_q), 0);
    check(!ovf_pulse && !wdt_tick_out, "R1 pulses", int'(ovf_pulse) + int'(wdt_tick_out), 0);

    // R2 / R8: internal source every clock, divider on watchdog
    phase = "R2";
    wr_opt(8'h08);
    wr_cnt(8'h10);
    clkn(2);
    check(cnt_q == 8'h10, "R8 hold after load", int'(cnt_q), 16);
    clkn(5);
    check(cnt_q == 8'h15, "R2 count per strobe", int'(cnt_q), 21);
    cyc_div = 4; cyc_ph = 0;
    wr_cnt(8'h20);
    clkn(16);
    check(cnt_q == 8'h22, "R2 sparse strobes with R8 hold", int'(cnt_q), 34);

    // R7 rollover
    phase = "R7";
    cyc_div = 1; cyc_ph = 0;
    wr_cnt(8'hFE);
    check(!ovf_pulse, "R7 no pulse on load", int'(ovf_pulse), 0);
    clkn(2);
    check(cnt_q == 8'hFE, "R7 held", int'(cnt_q), 254);
    clk1();
    check(cnt_q == 8'hFF && !ovf_pulse, "R7 top no pulse", int'(ovf_pulse), 0);
    clk1();
    check(cnt_q == 8'h00, "R7 wrapped", int'(cnt_q), 0);
    check(ovf_pulse, "R7 pulse", int'(ovf_pulse), 1);
    clk1();
    check(!ovf_pulse && cnt_q == 8'h01, "R7 pulse one cycle", int'(ovf_pulse), 0);

    // R5 divider on counter, rate 2 -> 1:8
    phase = "R5";
    wr_opt(8'h02);
    wr_cnt(8'h00);
    clkn(9);
    check(cnt_q == 8'h00, "R5 before eighth event", int'(cnt_q), 0);
    clk1();
    check(cnt_q == 8'h01, "R5 eighth event", int'(cnt_q), 1);
    clkn(16);
    check(cnt_q == 8'h03, "R5 two more periods", int'(cnt_q), 3);

    // R9 assignment switch clears divider (rate 1 -> 1:4)
    phase = "R9";
    wr_opt(8'h01);
    wr_cnt(8'h00);
    clkn(4);
    wr_opt(8'h09);
    wr_opt(8'h01);
    c0 = int'(cnt_q);
    clkn(3);
    check(int'(cnt_q) == c0, "R9 divider restarted", int'(cnt_q), c0);
    clk1();
    check(int'(cnt_q) == (c0 + 1) % 256, "R9 full ratio", int'(cnt_q), (c0 + 1) % 256);

    // R6 watchdog division, rate 3 -> 1:8
    phase = "R6";
    cyc_on = 1'b0;
    wr_opt(8'h0B);
    c0 = int'(cnt_q);
    wpulses = 0;
    wdt_tick_in = 1'b1;
    clkn(64);
    wdt_tick_in = 1'b0;
    clkn(2);
    check(wpulses == 8, "R6 rate 3 pulses", wpulses, 8);
    check(int'(cnt_q) == c0, "R6 counter untouched", int'(cnt_q), c0);
    wr_opt(8'h08);
    wpulses = 0;
    wdt_tick_in = 1'b1;
    clkn(10);
    wdt_tick_in = 1'b0;
    clkn(2);
    check(wpulses == 10, "R6 rate 0 passes all", wpulses, 10);
    wr_opt(8'h00);
    wpulses = 0;
    wdt_tick_in = 1'b1;
    clkn(20);
    wdt_tick_in = 1'b0;
    clk1();
    check(wpulses == 0, "R6 ignored when on counter", wpulses, 0);
    check(int'(cnt_q) == c0, "R6 wdt ticks do not count", int'(cnt_q), c0);

    // R3 external rising edge
    phase = "R3";
    cyc_on = 1'b1; cyc_div = 1; cyc_ph = 0;
    wr_opt(8'h28);
    wr_cnt(8'h30);
    clkn(3);
    check(cnt_q == 8'h30, "R3 idle pin", int'(cnt_q), 48);
    ext_clk_in = 1'b1;
    clkn(2);
    check(cnt_q == 8'h30, "R3 sync latency", int'(cnt_q), 48);
    clk1();
    check(cnt_q == 8'h31, "R3 rise counted", int'(cnt_q), 49);
    clkn(4);
    ext_clk_in = 1'b0;
    clkn(5);
    check(cnt_q == 8'h31, "R3 fall ignored", int'(cnt_q), 49);

    // R4 external falling edge
    phase = "R4";
    wr_opt(8'h38);
    ext_clk_in = 1'b1;
    clkn(5);
    check(cnt_q == 8'h31, "R4 rise ignored", int'(cnt_q), 49);
    ext_clk_in = 1'b0;
    clkn(2);
    check(cnt_q == 8'h31, "R4 sync latency", int'(cnt_q), 49);
    clk1();
    check(cnt_q == 8'h32, "R4 fall counted", int'(cnt_q), 50);

    // R10 option storage
    phase = "R10";
    wr_opt(8'hC8);
    check(opt_q == 8'hC8, "R10 readback", int'(opt_q), 200);

    // mixed traffic, compared every clock against the model
    phase = "R5 mixed";
    wr_opt(8'h21);
    for (int i = 0; i < 120; i++) begin
      if (i % 3 == 0) ext_clk_in = ~ext_clk_in;
      clk1();
    end
    phase = "R6 mixed";
    wr_opt(8'h3A);
    for (int i = 0; i < 120; i++) begin
      wdt_tick_in = (i % 2 == 0);
      if (i % 4 == 0) ext_clk_in = ~ext_clk_in;
      if (i == 50) begin cnt_wr = 1'b1; cnt_wdata = 8'hFD; end
      clk1();
      cnt_wr = 1'b0;
    end
    wdt_tick_in = 1'b0;
    clkn(4);

    done = 1'b1;
    running = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule